// File: doc/BRIEF.md
# Interrupt Source Gateway Array

This block keeps the per-source state of a set of wired interrupt sources. Sources are numbered 1 to NSRC-1. Number 0 is reserved and holds no state. Each source stores a sense mode, a pending bit, an enable bit and the input level it saw in the previous cycle. The inputs are already synchronous to `clk`. Every cycle, each source compares its input with the recorded level and, under its sense mode, may raise pending. The recorded level then follows the input.

Software works through one request port. Each cycle it carries an operation code and a source number. The operation is one of: write the configuration, set pending, clear pending, set enable or clear enable. A separate read index returns the full state of one source with no clock delay. Packed vectors expose the pending, enable and recorded-input bits of all sources at once.

Each source's pending bit behaves as a two-state machine with the states IDLE and PENDING:
- **IDLE to PENDING** ("raise"): a set request, or an input event that matches the mode.
- **PENDING to IDLE** ("drop"): a clear request while the source is not in a level mode.
- **PENDING to PENDING** ("hold"): any other cycle, including a clear request in a level mode.
- **IDLE to IDLE** ("hold"): any other cycle.

Top module: `irq_gateway_array`

## Requirements
- R1: Source number 0 and any number of NSRC or above are invalid. Requests addressed to them change no state. Reads of them return all zeros. Bit 0 of every state vector is always zero.
- R2: Reset clears every source: mode 0 (inactive), not pending, disabled, recorded input low.
- R3: In mode 4 (rising edge), pending becomes set one clock after a cycle in which the input is high, the recorded input is low and pending is clear.
- R4: In mode 5 (falling edge), pending becomes set one clock after a cycle in which the input is low and the recorded input is high.
- R5: In mode 6 (level high), pending becomes set one clock after any cycle with the input high. In mode 7 (level low), the same holds for any cycle with the input low.
- R6: A set-pending request (op 2) always sets pending. A clear-pending request (op 3) clears pending, except in modes 6 and 7, where it is ignored.
- R7: A configuration write (op 1) whose data has bit 10 set stores mode 0. Otherwise the source stores data bits 2:0 as its mode. A read returns the stored mode in bits 2:0 and zeros in bits 10:3.
- R8: In modes 0 (inactive), 1 (detached), 2 and 3, the input never changes pending. The input is still recorded.
- R9: A set-enable request (op 4) sets the enable bit and a clear-enable request (op 5) clears it. Op 0 is idle.
- R10: When a software pending request and an input event reach the same source in the same cycle, the software request decides the next pending value.
- R11: The recorded-input bit of each valid source equals that source's input one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Sampled input level per source; bit 0 unused |
| req_op | input | 3 | Request operation: 0 idle, 1 config write, 2 set pending, 3 clear pending, 4 set enable, 5 clear enable |
| req_idx | input | IDX_W | Source number of the request |
| req_wdata | input | 11 | Configuration write data |
| rd_idx | input | IDX_W | Source number to read |
| rd_cfg | output | 11 | Stored configuration of the read source |
| rd_pend | output | 1 | Pending bit of the read source |
| rd_en | output | 1 | Enable bit of the read source |
| rd_in | output | 1 | Recorded input of the read source |
| pend_vec | output | NSRC | Pending bits of all sources |
| en_vec | output | NSRC | Enable bits of all sources |
| in_vec | output | NSRC | Recorded inputs of all sources |

## Verification
The sweep gives the sources different modes in each pass, so all eight modes run side by side and see the same input stream. The stream includes steady-low, steady-high and alternating vectors, which separate the edge modes from the level modes. It also includes a walking one and pseudo-random vectors. In the random vectors, pending requests land on a source in the same cycle as its own edges, which exercises the priority rule and the level-mode clear rule. Each source is compared every cycle against a model built only from the rules above. Configuration writes with and without the override bit, and requests to invalid numbers, are checked through the read port and the vectors.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    localparam int CFG_W     = 11;
    localparam int DELEG_BIT = 10;
    localparam int MODE_W    = 3;

    typedef enum logic [MODE_W-1:0] {
        SM_INACTIVE = 3'd0,
        SM_DETACHED = 3'd1,
        SM_RSV2     = 3'd2,
        SM_RSV3     = 3'd3,
        SM_RISE     = 3'd4,
        SM_FALL     = 3'd5,
        SM_LVL_HI   = 3'd6,
        SM_LVL_LO   = 3'd7
    } src_mode_e;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_CFG   = 3'd1,
        OP_SETIP = 3'd2,
        OP_CLRIP = 3'd3,
        OP_SETIE = 3'd4,
        OP_CLRIE = 3'd5
    } req_op_e;

endpackage

// File: rtl/gw_req_decode.sv
module gw_req_decode
    import irq_gw_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 4
) (
    input  logic [2:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [CFG_W-1:0] req_wdata,
    output logic [NSRC-1:0]  cfg_we,
    output logic [NSRC-1:0]  setip,
    output logic [NSRC-1:0]  clrip,
    output logic [NSRC-1:0]  setie,
    output logic [NSRC-1:0]  clrie,
    output src_mode_e        cfg_mode
);

    logic [NSRC-1:0] hit;
    logic            unused_wbits;

    assign unused_wbits = ^req_wdata[DELEG_BIT-1:MODE_W];

    // one-hot source select; number 0 and numbers >= NSRC select nothing
    always_comb begin
        hit = '0;
        for (int s = 1; s < NSRC; s++) begin
            hit[s] = (req_idx == IDX_W'(s));
        end
    end

    always_comb begin
        cfg_we = '0;
        setip  = '0;
        clrip  = '0;
        setie  = '0;
        clrie  = '0;
        unique case (req_op)
            OP_CFG:   cfg_we = hit;
            OP_SETIP: setip  = hit;
            OP_CLRIP: clrip  = hit;
            OP_SETIE: setie  = hit;
            OP_CLRIE: clrie  = hit;
            default:  ;
        endcase
    end

    // override bit folds the whole word to the inactive mode
    assign cfg_mode = req_wdata[DELEG_BIT] ? SM_INACTIVE
                                           : src_mode_e'(req_wdata[MODE_W-1:0]);

    // R1: at most one strobe overall, none for invalid numbers
    always_comb begin
        p_one_strobe_r1: assert ($onehot0(cfg_we | setip | clrip | setie | clrie));
        if (req_idx == '0 || req_idx >= IDX_W'(NSRC)) begin
            p_no_strobe_invalid_r1: assert ((cfg_we | setip | clrip | setie | clrie) == '0);
        end
    end

endmodule

// File: rtl/gw_src_cell.sv
module gw_src_cell
    import irq_gw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_lvl,
    input  logic      cfg_we,
    input  src_mode_e cfg_mode,
    input  logic      setip,
    input  logic      clrip,
    input  logic      setie,
    input  logic      clrie,
    output src_mode_e mode_q,
    output logic      pend_q,
    output logic      en_q,
    output logic      in_q
);

    logic      hw_set;
    logic      is_level;
    logic      pend_d;
    logic      en_d;
    src_mode_e mode_d;

    // input event detection per sense mode
    always_comb begin
        unique case (mode_q)
            SM_RISE:   hw_set = in_lvl && !in_q && !pend_q;
            SM_FALL:   hw_set = !in_lvl && in_q;
            SM_LVL_HI: hw_set = in_lvl;
            SM_LVL_LO: hw_set = !in_lvl;
            default:   hw_set = 1'b0;
        endcase
    end

    assign is_level = (mode_q == SM_LVL_HI) || (mode_q == SM_LVL_LO);

    // next state: software first, then the input event
    always_comb begin
        if (setip) begin
            pend_d = 1'b1;
        end else if (clrip && !is_level) begin
            pend_d = 1'b0;
        end else if (hw_set) begin
            pend_d = 1'b1;
        end else begin
            pend_d = pend_q;
        end
        if (setie) begin
            en_d = 1'b1;
        end else if (clrie) begin
            en_d = 1'b0;
        end else begin
            en_d = en_q;
        end
        mode_d = cfg_we ? cfg_mode : mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SM_INACTIVE;
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            in_q   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            pend_q <= pend_d;
            en_q   <= en_d;
            in_q   <= in_lvl;
        end
    end

    p_set_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        setip |=> pend_q);

    p_level_clr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clrip && is_level && pend_q) |=> pend_q);

    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SM_RISE && in_lvl && !in_q && !clrip) |=> pend_q);

    p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SM_FALL && !in_lvl && in_q && !clrip) |=> pend_q);

    p_level_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SM_LVL_HI && in_lvl) |=> pend_q);

    p_quiet_modes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == SM_INACTIVE || mode_q == SM_DETACHED ||
          mode_q == SM_RSV2 || mode_q == SM_RSV3) && !setip && !clrip)
        |=> $stable(pend_q));

    p_sw_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clrip && !is_level && !setip) |=> !pend_q);

    p_in_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (in_q == $past(in_lvl)));

endmodule

// File: rtl/gw_read_mux.sv
module gw_read_mux
    import irq_gw_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [NSRC-1:0][MODE_W-1:0]  mode_flat,
    input  logic [NSRC-1:0]              pend_vec,
    input  logic [NSRC-1:0]              en_vec,
    input  logic [NSRC-1:0]              in_vec,
    output logic [CFG_W-1:0]             rd_cfg,
    output logic                         rd_pend,
    output logic                         rd_en,
    output logic                         rd_in
);

    always_comb begin
        rd_cfg  = '0;
        rd_pend = 1'b0;
        rd_en   = 1'b0;
        rd_in   = 1'b0;
        for (int s = 1; s < NSRC; s++) begin
            if (rd_idx == IDX_W'(s)) begin
                rd_cfg  = CFG_W'(mode_flat[s]);
                rd_pend = pend_vec[s];
                rd_en   = en_vec[s];
                rd_in   = in_vec[s];
            end
        end
    end

endmodule

// File: rtl/irq_gateway_array.sv
module irq_gateway_array
    import irq_gw_pkg::*;
#(
    parameter  int NSRC  = 8,
    localparam int IDX_W = $clog2(NSRC) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_in,
    input  logic [2:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [CFG_W-1:0] req_wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CFG_W-1:0] rd_cfg,
    output logic             rd_pend,
    output logic             rd_en,
    output logic             rd_in,
    output logic [NSRC-1:0]  pend_vec,
    output logic [NSRC-1:0]  en_vec,
    output logic [NSRC-1:0]  in_vec
);

    logic [NSRC-1:0]             cfg_we;
    logic [NSRC-1:0]             setip;
    logic [NSRC-1:0]             clrip;
    logic [NSRC-1:0]             setie;
    logic [NSRC-1:0]             clrie;
    src_mode_e                   cfg_mode;
    logic [NSRC-1:0][MODE_W-1:0] mode_flat;
    logic                        unused_ctl;

    assign unused_ctl = ^{src_in[0], cfg_we[0], setip[0], clrip[0], setie[0], clrie[0]};

    gw_req_decode #(.NSRC(NSRC), .IDX_W(IDX_W)) u_dec (
        .req_op    (req_op),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .cfg_we    (cfg_we),
        .setip     (setip),
        .clrip     (clrip),
        .setie     (setie),
        .clrie     (clrie),
        .cfg_mode  (cfg_mode)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s == 0) begin : g_none
            assign mode_flat[s] = '0;
            assign pend_vec[s]  = 1'b0;
            assign en_vec[s]    = 1'b0;
            assign in_vec[s]    = 1'b0;
        end else begin : g_cell
            src_mode_e mode_s;
            gw_src_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_lvl   (src_in[s]),
                .cfg_we   (cfg_we[s]),
                .cfg_mode (cfg_mode),
                .setip    (setip[s]),
                .clrip    (clrip[s]),
                .setie    (setie[s]),
                .clrie    (clrie[s]),
                .mode_q   (mode_s),
                .pend_q   (pend_vec[s]),
                .en_q     (en_vec[s]),
                .in_q     (in_vec[s])
            );
            assign mode_flat[s] = mode_s;
        end
    end

    gw_read_mux #(.NSRC(NSRC), .IDX_W(IDX_W)) u_rd (
        .rd_idx    (rd_idx),
        .mode_flat (mode_flat),
        .pend_vec  (pend_vec),
        .en_vec    (en_vec),
        .in_vec    (in_vec),
        .rd_cfg    (rd_cfg),
        .rd_pend   (rd_pend),
        .rd_en     (rd_en),
        .rd_in     (rd_in)
    );

    p_rd_invalid_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0 || rd_idx >= IDX_W'(NSRC))
        |-> (rd_cfg == '0 && !rd_pend && !rd_en && !rd_in));

    p_cfg_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_CFG && req_wdata[DELEG_BIT] && rd_idx == req_idx)
        |=> (rd_cfg == '0 || rd_idx != $past(rd_idx)));

endmodule

// File: tb/irq_gateway_array_test.sv
module irq_gateway_array_test;

    localparam int NSRC       = 8;
    localparam int IDX_W      = $clog2(NSRC) + 1;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NSRC-1:0]  src_in;
    logic [2:0]       req_op;
    logic [IDX_W-1:0] req_idx;
    logic [10:0]      req_wdata;
    logic [IDX_W-1:0] rd_idx;
    logic [10:0]      rd_cfg;
    logic             rd_pend, rd_en, rd_in;
    logic [NSRC-1:0]  pend_vec, en_vec, in_vec;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    int m_mode [NSRC];
    bit m_pend [NSRC];
    bit m_en   [NSRC];
    bit m_in   [NSRC];

    logic [15:0] lf = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_gateway_array #(.NSRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .req_op(req_op),
        .req_idx(req_idx), .req_wdata(req_wdata), .rd_idx(rd_idx),
        .rd_cfg(rd_cfg), .rd_pend(rd_pend), .rd_en(rd_en), .rd_in(rd_in),
        .pend_vec(pend_vec), .en_vec(en_vec), .in_vec(in_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic model_reset();
        for (int s = 0; s < NSRC; s++) begin
            m_mode[s] = 0; m_pend[s] = 0; m_en[s] = 0; m_in[s] = 0;
        end
    endtask

    task automatic rdchk(input int idx, input string tag);
        logic [31:0] exp;
        rd_idx = IDX_W'(idx);
        #1;
        if (idx >= 1 && idx < NSRC)
            exp = {m_mode[idx][10:0], m_pend[idx], m_en[idx], m_in[idx]};
        else
            exp = 0;
        chk(tag, {rd_cfg, rd_pend, rd_en, rd_in}, exp);
    endtask

    // drive one request and input vector, advance one clock, compare all sources
    task automatic cyc(input int op, input int idx, input int wdata, input logic [NSRC-1:0] vin);
        bit    np [NSRC];
        bit    ne [NSRC];
        int    nm [NSRC];
        string tg [NSRC];
        req_op    = 3'(op);
        req_idx   = IDX_W'(idx);
        req_wdata = 11'(wdata);
        src_in    = vin;
        for (int s = 0; s < NSRC; s++) begin
            bit hit, lvl, hw, setp, clrp;
            np[s] = m_pend[s]; ne[s] = m_en[s]; nm[s] = m_mode[s];
            tg[s] = "R1";
            if (s != 0) begin
                hit  = (idx == s);
                lvl  = (m_mode[s] == 6) || (m_mode[s] == 7);
                case (m_mode[s])
                    4: hw = vin[s] && !m_in[s] && !m_pend[s];
                    5: hw = !vin[s] && m_in[s];
                    6: hw = vin[s];
                    7: hw = !vin[s];
                    default: hw = 0;
                endcase
                setp = hit && op == 2;
                clrp = hit && op == 3;
                if (setp) np[s] = 1;
                else if (clrp && !lvl) np[s] = 0;
                else if (hw) np[s] = 1;
                if (clrp && hw && !lvl) tg[s] = "R10";
                else if (setp || clrp) tg[s] = "R6";
                else if (m_mode[s] == 4) tg[s] = "R3";
                else if (m_mode[s] == 5) tg[s] = "R4";
                else if (lvl) tg[s] = "R5";
                else tg[s] = "R8";
                if (hit && op == 4) ne[s] = 1;
                if (hit && op == 5) ne[s] = 0;
                if (hit && op == 1) nm[s] = wdata[10] ? 0 : (wdata & 7);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < NSRC; s++) begin
            m_pend[s] = np[s]; m_en[s] = ne[s]; m_mode[s] = nm[s];
            m_in[s] = (s != 0) ? vin[s] : 1'b0;
            chk(tg[s], {31'd0, pend_vec[s]}, {31'd0, m_pend[s]});
            chk((s == 0) ? "R1" : "R9", {31'd0, en_vec[s]}, {31'd0, m_en[s]});
            chk((s == 0) ? "R1" : "R11", {31'd0, in_vec[s]}, {31'd0, m_in[s]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0] v;
        rst_n = 0; src_in = '1; req_op = 0; req_idx = 0; req_wdata = 0; rd_idx = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R2: state cleared while reset is held
        chk("R2", {8'd0, pend_vec, en_vec, in_vec}, 0);
        for (int i = 0; i < 2 * NSRC; i++) rdchk(i, "R2");
        src_in = '0;
        rst_n  = 1;
        @(negedge clk);
        chk("R2", {8'd0, pend_vec, en_vec, in_vec}, 0);

        // R7: config writes keep bits 2:0, override bit 10 folds to zero
        for (int s = 1; s < NSRC; s++) begin
            cyc(1, s, 11'h3F8 | (s & 7), '0);
            rdchk(s, "R7");
            cyc(1, s, 11'h406, '0);
            rdchk(s, "R7");
            cyc(1, s, 11'h7FD, '0);
            rdchk(s, "R7");
        end

        // R1: every operation on invalid numbers is ignored
        for (int op = 1; op <= 5; op++) begin
            cyc(op, 0, 11'h006, '1);
            for (int idx = NSRC; idx < 2 * NSRC; idx++) cyc(op, idx, 11'h006, '1);
        end
        for (int i = 0; i < 2 * NSRC; i++) if (i == 0 || i >= NSRC) rdchk(i, "R1");

        // mode sweep: source s takes mode (s + rot) mod 8
        for (int rot = 0; rot < 8; rot++) begin
            v = '0;
            for (int s = 1; s < NSRC; s++) cyc(1, s, (s + rot) % 8, v);
            for (int s = 1; s < NSRC; s++) cyc(3, s, 0, v);
            for (int s = 1; s < NSRC; s++) rdchk(s, "R7");
            cyc(0, 0, 0, '0);
            cyc(0, 0, 0, '1);
            cyc(0, 0, 0, '1);
            for (int s = 1; s < NSRC; s++) cyc(3, s, 0, '1);
            cyc(0, 0, 0, '0);
            for (int k = 0; k < 4; k++) begin
                cyc(0, 0, 0, 8'hAA);
                cyc(0, 0, 0, 8'h55);
            end
            for (int s = 0; s < NSRC; s++) cyc(3, s, 0, NSRC'(1) << s);
            for (int k = 0; k < 48; k++) begin
                int op, idx;
                lf_step();
                v   = lf[NSRC-1:0];
                op  = (lf[9:8] == 2'd0) ? 0 : ((lf[12:10] % 5) + 1);
                idx = int'(lf[15:12]);
                if (op == 1) op = 2;
                cyc(op, idx, 0, v);
            end
            for (int s = 1; s < NSRC; s++) rdchk(s, "R11");
        end

        // R10: clear meets a rising edge in the same cycle on source 3
        cyc(1, 3, 4, '0);
        cyc(3, 3, 0, '0);
        cyc(3, 3, 0, 8'h08);
        rdchk(3, "R10");
        // falling edge against clear on source 2
        cyc(1, 2, 5, 8'h04);
        cyc(3, 2, 0, 8'h04);
        cyc(3, 2, 0, 8'h00);
        rdchk(2, "R10");
        // R6: clear ignored in level-low with input low
        cyc(1, 5, 7, '0);
        cyc(0, 0, 0, '0);
        cyc(3, 5, 0, '0);
        rdchk(5, "R6");
        // R9: enable set then clear
        cyc(4, 6, 0, '0);
        rdchk(6, "R9");
        cyc(5, 6, 0, '0);
        rdchk(6, "R9");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule